// File: doc/BRIEF.md
# SPI Master Transfer Engine with Chip-Select Policies

This block drives one SPI slave over a single data lane in clock mode 0: SCK idles low, the master changes MOSI after a falling edge and samples MISO on the rising edge, most significant bit first. Each character is 8 or 16 bits wide. A 32-bit mode word sets the character width, internal loopback, an optional gate that holds a new character until the previous receive data has been taken, the spacing between characters, and the shortest time chip select must stay high.

Transmit characters enter through a valid/ready port. A character is accepted on any clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the single holding slot is occupied, so the producer waits and the held word stays unchanged. Received characters leave through a valid/ready port. `rx_valid` stays high until a clock edge sees `rx_ready` high. The engine never waits for the consumer unless the read gate is on. Without the gate, a new character overwrites unread data and sets a sticky overrun flag.

Three policies decide when chip select is released after a character: when no next character is waiting, when a character tagged as last has gone out, or after every character.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `spi_cs_n` is 1, `spi_sck` is 0, `tx_ready` is 1, and both `rx_valid` and `overrun` are 0.
- R2: A clock edge with `cfg_we` high stores all 32 bits of `cfg_wdata`, and `cfg_rdata` returns them. The field layout is:
  - bit 0: free storage
  - bit 1: loopback
  - bit 2: read gate
  - bits 5:4: chip-select policy
  - bits 11:8: width code
  - bits 23:16: character gap
  - bits 31:24: minimum idle time
- R3: With width code 0, each character is 8 SCK pulses carrying `tx_data[7:0]` MSB first. The 8 bits sampled from MISO appear in `rx_data[7:0]`, with the upper byte zero. SCK only pulses while `spi_cs_n` is low.
- R4: With width code 8, each character is 16 SCK pulses carrying `tx_data[15:0]` MSB first, and all 16 sampled bits appear in `rx_data`.
- R5: With loopback (bit 1) set, the sampled data is the MOSI stream, so `rx_data` equals the transmitted character whatever `spi_miso` does.
- R6: Policy 0 releases chip select at the end of a character only if no next character was held at that moment. Two back-to-back characters therefore share one chip-select assertion.
- R7: Policy 1 keeps chip select low between characters, even while idle, until a character accepted with `tx_last` = 1 has been shifted out. It then releases chip select.
- R8: Policy 2 releases chip select after every character, and policy code 3 behaves the same way.
- R9: With the read gate (bit 2) set, no character starts while `rx_valid` is high. The next character starts once the receive data has been taken.
- R10: Between two characters inside one chip-select assertion, the engine adds 32 × gap system clocks of idle. A gap of 0 adds none.
- R11: After release, `spi_cs_n` stays high for at least the minimum idle time in system clocks, and at least one clock when that field is 0.
- R12: While `tx_ready` is low, the held character is neither changed nor lost. It is the next one shifted out.
- R13: A completed character sets `rx_valid`, and a clock edge with `rx_ready` high clears it. A character that completes while `rx_valid` is high and `rx_ready` is low sets `overrun`. `overrun` stays set until a pulse on `ovr_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word to store |
| cfg_rdata | output | 32 | Stored mode word |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Holding slot empty, character will be taken |
| tx_data | input | 16 | Transmit character (low byte in 8-bit mode) |
| tx_last | input | 1 | Tag character as last of a chip-select frame (policy 1) |
| rx_valid | output | 1 | Receive character waiting |
| rx_ready | input | 1 | Consumer takes the receive character |
| rx_data | output | 16 | Received character |
| overrun | output | 1 | Sticky: receive data was overwritten |
| ovr_clr | input | 1 | Clears `overrun` |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
- The engine finishes a character on the edge that drives the last SCK fall. `rx_valid`, `overrun` and a chip-select release all appear on that same edge, one holding-slot register after the decision inputs.
- The bench polls those outputs on falling clock edges, so every sample lands half a clock after the register that drives it.
- Gap and idle times are checked as differences between timestamps taken on SCK and chip-select edges. The fixed pipeline offset of one or two clocks cancels out in these differences (gap 2 against gap 0 must differ by exactly 64 clocks), or sits inside a tight window (idle time 20 gives 20 to 22 clocks).
- Checks that something must not happen, such as a gated start, a kept chip select or a held word, watch the SCK pulse count and the pins for tens of clocks beyond the point where the event would otherwise have occurred.

// File: rtl/spi_cm_pkg.sv
package spi_cm_pkg;

  localparam int DLY_W        = 8;
  localparam logic [3:0] WCODE_WIDE = 4'd8;

  typedef enum logic [1:0] {
    CSP_NO_RELOAD = 2'd0,
    CSP_LAST_FLAG = 2'd1,
    CSP_EACH      = 2'd2,
    CSP_EACH_ALT  = 2'd3
  } cs_policy_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_GAP,
    SQ_HOLD
  } seq_state_e;

  // Packed view of the 32-bit mode word; field positions are what software writes.
  typedef struct packed {
    logic [DLY_W-1:0] cs_idle;
    logic [DLY_W-1:0] gap;
    logic [3:0]       rsv_hi;
    logic [3:0]       width_code;
    logic [1:0]       rsv_mid;
    cs_policy_e       policy;
    logic             rsv_lo;
    logic             wait_rd;
    logic             loopback;
    logic             mem_sel;
  } mode_t;

endpackage

// File: rtl/spi_cm_mode.sv
module spi_cm_mode
  import spi_cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output mode_t       mode
);

  logic [31:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (we) word_q <= wdata;
  end

  assign rdata = word_q;
  assign mode  = mode_t'(word_q);

endmodule

// File: rtl/spi_cm_shift.sv
module spi_cm_shift #(
  parameter int CHAR_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [CHAR_W-1:0] tx_word,
  input  logic              miso_in,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [CHAR_W-1:0] rx_word
);

  localparam int HC_W   = $clog2(HALF_DIV + 1);
  localparam int BC_W   = $clog2(CHAR_W + 1);
  localparam int NARROW = CHAR_W / 2;

  logic              active;
  logic [HC_W-1:0]   hcnt;
  logic [BC_W-1:0]   bits_left;
  logic [CHAR_W-1:0] sh_out;
  logic [CHAR_W-1:0] sh_in;
  logic              sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      hcnt      <= '0;
      bits_left <= '0;
      sh_out    <= '0;
      sh_in     <= '0;
      sck_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        hcnt      <= '0;
        sck_q     <= 1'b0;
        sh_in     <= '0;
        sh_out    <= wide ? tx_word : {tx_word[NARROW-1:0], {NARROW{1'b0}}};
        bits_left <= wide ? BC_W'(CHAR_W) : BC_W'(NARROW);
      end else if (active) begin
        if (hcnt == HC_W'(HALF_DIV - 1)) begin
          hcnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            sh_in <= {sh_in[CHAR_W-2:0], miso_in};
          end else begin
            sck_q     <= 1'b0;
            sh_out    <= sh_out << 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == BC_W'(1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = sh_out[CHAR_W-1];
  assign rx_word = sh_in;

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active); // R3

  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sck_q && $past(sck_q)); // R3

endmodule

// File: rtl/spi_cm_seq.sv
module spi_cm_seq
  import spi_cm_pkg::*;
#(
  parameter int GAP_SCALE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cs_policy_e       policy,
  input  logic             wait_rd,
  input  logic [DLY_W-1:0] gap,
  input  logic [DLY_W-1:0] cs_idle,
  input  logic             tx_full,
  input  logic             tx_last,
  input  logic             rx_full,
  input  logic             done,
  output logic             start,
  output logic             cs_n
);

  localparam int CNT_W = DLY_W + $clog2(GAP_SCALE) + 1;

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             cur_last;
  logic             can_go;
  logic             release_now;

  assign can_go = tx_full && !(wait_rd && rx_full);
  assign start  = can_go && ((st == SQ_IDLE) || (st == SQ_GAP && cnt == '0));

  always_comb begin
    unique case (policy)
      CSP_NO_RELOAD: release_now = !tx_full;
      CSP_LAST_FLAG: release_now = cur_last;
      default:       release_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      cs_n     <= 1'b1;
      cur_last <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          st       <= SQ_XFER;
          cs_n     <= 1'b0;
          cur_last <= tx_last;
        end
        SQ_XFER: if (done) begin
          if (release_now) begin
            st   <= SQ_HOLD;
            cs_n <= 1'b1;
            cnt  <= (cs_idle == '0) ? CNT_W'(1) : CNT_W'(cs_idle);
          end else begin
            st  <= SQ_GAP;
            cnt <= CNT_W'(gap) * CNT_W'(GAP_SCALE);
          end
        end
        SQ_GAP: begin
          if (start) begin
            st       <= SQ_XFER;
            cur_last <= tx_last;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_HOLD: begin
          if (cnt == CNT_W'(1)) st <= SQ_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R11

  AST_EACH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && policy[1]) |=> cs_n); // R8

  AST_GAP_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_GAP) |-> !cs_n); // R6

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_cm_pkg::*;
#(
  parameter int CHAR_W    = 16,
  parameter int HALF_DIV  = 2,
  parameter int GAP_SCALE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              overrun,
  input  logic              ovr_clr,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  mode_t             mode;
  logic              tx_full;
  logic [CHAR_W-1:0] tx_hold;
  logic              tx_hold_last;
  logic              start;
  logic              done;
  logic [CHAR_W-1:0] rx_word;
  logic              miso_in;

  spi_cm_mode u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .mode  (mode)
  );

  spi_cm_seq #(.GAP_SCALE(GAP_SCALE)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .policy  (mode.policy),
    .wait_rd (mode.wait_rd),
    .gap     (mode.gap),
    .cs_idle (mode.cs_idle),
    .tx_full (tx_full),
    .tx_last (tx_hold_last),
    .rx_full (rx_valid),
    .done    (done),
    .start   (start),
    .cs_n    (spi_cs_n)
  );

  assign miso_in = mode.loopback ? spi_mosi : spi_miso;

  spi_cm_shift #(.CHAR_W(CHAR_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wide    (mode.width_code == WCODE_WIDE),
    .tx_word (tx_hold),
    .miso_in (miso_in),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (done),
    .rx_word (rx_word)
  );

  assign tx_ready = !tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full      <= 1'b0;
      tx_hold      <= '0;
      tx_hold_last <= 1'b0;
    end else begin
      if (start) tx_full <= 1'b0;
      if (tx_valid && tx_ready) begin
        tx_full      <= 1'b1;
        tx_hold      <= tx_data;
        tx_hold_last <= tx_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (ovr_clr) overrun <= 1'b0;
      if (done) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_word;
        if (rx_valid && !rx_ready) overrun <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n); // R3

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !start) |=> $stable(tx_hold)); // R12

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode.wait_rd) |-> !rx_valid); // R9

  AST_RX_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid); // R13

  AST_OVR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_valid && !rx_ready) |=> overrun); // R13

endmodule

// File: tb/spi_chain_master_test.sv
module spi_chain_master_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        tx_last = 1'b0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        overrun;
  logic        ovr_clr = 1'b0;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int fails  = 0;

  spi_chain_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .overrun(overrun),
    .ovr_clr(ovr_clr), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #5 clk = ~clk;

  // Passive observers of the serial pins.
  int          cyc = 0;
  int          rises = 0, falls = 0, last_fall = 0, big_gap = 0;
  int          rel_cnt = 0, rel_t = 0, idle_len = 0, fall_base = 0;
  logic [31:0] mon = '0;
  logic [15:0] slave_word = '0;
  logic [15:0] slave_l = '0;
  int          sidx;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge spi_sck) begin
    rises <= rises + 1;
    mon   <= {mon[30:0], spi_mosi};
    if (cyc - last_fall > HALF) big_gap <= cyc - last_fall;
  end
  always @(negedge spi_sck) begin
    falls     <= falls + 1;
    last_fall <= cyc;
  end
  always @(posedge spi_cs_n) begin
    rel_cnt <= rel_cnt + 1;
    rel_t   <= cyc;
  end
  always @(negedge spi_cs_n) begin
    idle_len  <= cyc - rel_t;
    fall_base <= falls;
    slave_l   <= slave_word;
  end
  assign sidx     = falls - fall_base;
  assign spi_miso = (sidx >= 0 && sidx < 16) ? slave_l[15 - sidx] : 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mode(logic [7:0] idle, logic [7:0] gap,
      logic [3:0] wcode, logic [1:0] pol, logic gate, logic lb);
    return {idle, gap, 4'b0, wcode, 2'b0, pol, 1'b0, gate, lb, 1'b0};
  endfunction

  task automatic set_mode(logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(logic [15:0] d, logic last);
    @(negedge clk); tx_valid = 1'b1; tx_data = d; tx_last = last;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_rises(int target);
    while (rises < target) @(negedge clk);
  endtask

  task automatic take_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_ovr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cfg", cfg_rdata, 32'h0);
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk("R1 sck", {31'b0, spi_sck}, 32'h0);
    chk("R1 tx_ready", {31'b0, tx_ready}, 32'h1);
    chk("R1 rx_valid", {31'b0, rx_valid}, 32'h0);
    chk("R1 overrun", {31'b0, overrun}, 32'h0);
  endtask

  task automatic t_mode_rw();
    set_mode(32'hA5C3_5A69);
    @(negedge clk);
    chk("R2 readback", cfg_rdata, 32'hA5C3_5A69);
    set_mode(32'h0000_0001);
    @(negedge clk);
    chk("R2 readback bit0", cfg_rdata, 32'h0000_0001);
  endtask

  task automatic t_byte();
    int r0, c0;
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd2, 1'b0, 1'b0));
    slave_word = 16'h3C00;
    r0 = rises; c0 = rel_cnt;
    send(16'h12A7, 1'b0);
    while (!rx_valid) @(negedge clk);
    chk("R3 pulses", 32'(rises - r0), 32'd8);
    chk("R3 mosi", {24'b0, mon[7:0]}, 32'h0000_00A7);
    chk("R3 rx_data", {16'b0, rx_data}, 32'h0000_003C);
    chk("R8 release", {31'b0, spi_cs_n}, 32'h1);
    take_rx();
    chk("R13 rx cleared", {31'b0, rx_valid}, 32'h0);
    // policy code 3 also releases after each character
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd3, 1'b0, 1'b0));
    send(16'h0081, 1'b0);
    while (!rx_valid) @(negedge clk);
    chk("R8 code3 release", 32'(rel_cnt - c0), 32'd2);
    take_rx();
  endtask

  task automatic t_word();
    int r0;
    set_mode(mk_mode(8'd0, 8'd0, 4'd8, 2'd2, 1'b0, 1'b0));
    slave_word = 16'h1234;
    r0 = rises;
    send(16'hBEEF, 1'b0);
    while (!rx_valid) @(negedge clk);
    chk("R4 pulses", 32'(rises - r0), 32'd16);
    chk("R4 mosi", {16'b0, mon[15:0]}, 32'h0000_BEEF);
    chk("R4 rx_data", {16'b0, rx_data}, 32'h0000_1234);
    take_rx();
  endtask

  task automatic t_loop();
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd2, 1'b0, 1'b1));
    slave_word = 16'hFF00;
    send(16'h005A, 1'b0);
    while (!rx_valid) @(negedge clk);
    chk("R5 loopback data", {16'b0, rx_data}, 32'h0000_005A);
    take_rx();
  endtask

  task automatic t_pol0();
    int r0, c0;
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd0, 1'b0, 1'b1));
    r0 = rises; c0 = rel_cnt;
    send(16'h0001, 1'b0);
    send(16'h0002, 1'b0);
    wait_rises(r0 + 16);
    repeat (20) @(negedge clk);
    chk("R6 one release", 32'(rel_cnt - c0), 32'd1);
    chk("R6 released", {31'b0, spi_cs_n}, 32'h1);
    chk("R13 overrun set", {31'b0, overrun}, 32'h1);
    chk("R13 newest kept", {16'b0, rx_data}, 32'h0000_0002);
    clear_ovr();
    chk("R13 overrun cleared", {31'b0, overrun}, 32'h0);
    take_rx();
  endtask

  task automatic t_pol1();
    int r0, c0;
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd1, 1'b0, 1'b1));
    r0 = rises; c0 = rel_cnt;
    send(16'h0010, 1'b0);
    wait_rises(r0 + 8);
    repeat (100) @(negedge clk);
    chk("R7 cs kept", {31'b0, spi_cs_n}, 32'h0);
    chk("R7 no release", 32'(rel_cnt - c0), 32'd0);
    take_rx();
    send(16'h0020, 1'b1);
    while (!rx_valid) @(negedge clk);
    chk("R7 released after last", {31'b0, spi_cs_n}, 32'h1);
    chk("R7 one release", 32'(rel_cnt - c0), 32'd1);
    take_rx();
  endtask

  task automatic t_gate();
    int r0;
    logic ready_seen;
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd2, 1'b1, 1'b1));
    r0 = rises;
    send(16'h0011, 1'b0);
    while (!rx_valid) @(negedge clk);
    send(16'h0022, 1'b0);
    ready_seen = 1'b0;
    tx_valid = 1'b1; tx_data = 16'h0033;
    repeat (60) begin
      @(negedge clk);
      if (tx_ready) ready_seen = 1'b1;
    end
    tx_valid = 1'b0;
    chk("R9 held off", 32'(rises - r0), 32'd8);
    chk("R12 no ready while full", {31'b0, ready_seen}, 32'h0);
    chk("R9 first data", {16'b0, rx_data}, 32'h0000_0011);
    take_rx();
    while (!rx_valid) @(negedge clk);
    chk("R9 resumed", 32'(rises - r0), 32'd16);
    chk("R12 held word sent", {16'b0, rx_data}, 32'h0000_0022);
    chk("R9 no overrun", {31'b0, overrun}, 32'h0);
    take_rx();
  endtask

  task automatic t_gap();
    int r0, g0, g2;
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd1, 1'b0, 1'b1));
    r0 = rises;
    send(16'h00C1, 1'b0);
    send(16'h00C2, 1'b1);
    wait_rises(r0 + 16);
    repeat (10) @(negedge clk);
    g0 = big_gap;
    set_mode(mk_mode(8'd0, 8'd2, 4'd0, 2'd1, 1'b0, 1'b1));
    r0 = rises;
    send(16'h00D1, 1'b0);
    send(16'h00D2, 1'b1);
    wait_rises(r0 + 16);
    repeat (10) @(negedge clk);
    g2 = big_gap;
    chk("R10 gap scale", 32'(g2 - g0), 32'd64);
    chk("R10 gap zero small", {31'b0, (g0 <= 2 * HALF + 2)}, 32'h1);
    take_rx();
    clear_ovr();
  endtask

  task automatic t_idle();
    int r0;
    set_mode(mk_mode(8'd20, 8'd0, 4'd0, 2'd2, 1'b0, 1'b1));
    r0 = rises;
    send(16'h00E1, 1'b0);
    send(16'h00E2, 1'b0);
    wait_rises(r0 + 16);
    repeat (10) @(negedge clk);
    chk("R11 idle 20", {31'b0, (idle_len >= 20 && idle_len <= 22)}, 32'h1);
    set_mode(mk_mode(8'd0, 8'd0, 4'd0, 2'd2, 1'b0, 1'b1));
    r0 = rises;
    send(16'h00F1, 1'b0);
    send(16'h00F2, 1'b0);
    wait_rises(r0 + 16);
    repeat (10) @(negedge clk);
    chk("R11 idle 0", {31'b0, (idle_len >= 1 && idle_len <= 3)}, 32'h1);
    take_rx();
    clear_ovr();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_rw();
    t_byte();
    t_word();
    t_loop();
    t_pol0();
    t_pol1();
    t_gate();
    t_gap();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule